// File: doc/BRIEF.md
# Glitch-Free Cross-Domain Mailbox Attention Flag

This block watches host accesses on an asynchronous expansion bus and raises a sticky attention flag in the main clock domain when the host writes the mailbox register. The bus side is clocked only by the bus command strobe. On the rising edge of the strobe it captures the operation-active line, the active-low write line, the register address and the write data. On the falling edge of the same strobe it registers the complete mailbox decode and, on a hit, the mailbox data word.

The registered decode bit drives the first stage of a three-stage synchronizer in the main domain, with no gate in between. A separate main-domain flop remembers the previous synchronized level, so that only a rising edge of that level produces a one-cycle set pulse. The set pulse is the only thing that can raise the flag. Firmware in the main domain reads the data word once the flag is up and drops the flag with a one-cycle clear pulse.

Because every decode term is held in a flop before it leaves the bus domain, a short hazard on the comparator cannot reach the synchronizer. The same holds for a runt pulse on the address or control pins between strobes.

Top module: `mbx_attn_cdc`

## Requirements
- R1: While `rst_n` is low and just after it is released, `mbx_flag` is 0 and `mbx_data` is 0.
- R2: A mailbox write (`bus_op`=1, `bus_wr_n`=0 and `bus_addr`=MBX_ADDR, default 4'hA, all sampled on the rising edge of `bus_cmd`) sets `mbx_flag`. The flag rises on the 4th rising edge of `main_clk` after the falling edge of `bus_cmd`, and not before the 4th, provided that falling edge lies half a period away from a `main_clk` rising edge.
- R3: An access with a different address, a read (`bus_wr_n`=1), or a strobe with `bus_op`=0 never sets `mbx_flag`.
- R4: Once set, `mbx_flag` stays at 1 until a clear is applied.
- R5: A one-cycle `mbx_clr` pulse with no set event in the same cycle drops `mbx_flag` to 0 at the `main_clk` edge that samples it.
- R6: When a set event and `mbx_clr` are sampled at the same `main_clk` edge, `mbx_flag` ends up 1.
- R7: `mbx_data` takes `bus_wdata` on each mailbox write and holds its value across all other accesses.
- R8: Pulses shorter than 3 ns on `bus_op`, `bus_wr_n`, `bus_addr` or `bus_wdata` with no `bus_cmd` edge change neither `mbx_flag` nor `mbx_data`.
- R9: The flag is set by the rising edge of the registered decode level, not by the level itself. After a clear, a second mailbox write with no other access in between does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_cmd | input | 1 | Bus command strobe; rising edge captures pins, falling edge registers the decode |
| bus_op | input | 1 | Bus operation active (high) |
| bus_wr_n | input | 1 | Write when low, read when high |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Host write data |
| main_clk | input | 1 | Main domain clock |
| mbx_clr | input | 1 | One-cycle flag clear, main domain |
| mbx_flag | output | 1 | Sticky mailbox attention flag |
| mbx_data | output | DATA_W | Last mailbox word written by the host |

## Verification
The decode level is registered on the strobe's falling edge, then passes three synchronizer flops and one flag flop. The flag is therefore due on the fourth `main_clk` rising edge after that fall. The bench drops the strobe exactly on a `main_clk` falling edge and counts falling edges from there: it expects 0 after the second and third and 1 after the fourth. A clear is sampled at the first rising edge after it is driven, so its effect is checked at the next falling edge. To hit the set-versus-clear case, the clear is driven after the third falling edge, so that it lands on the same rising edge as the set pulse. Negative cases (wrong address, read, inactive operation, runt pulses and a repeated write) are each given at least eight cycles, which is more than the full latency, before the flag and data are checked.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Full mailbox-hit decode: active operation, active-low write, matching address.
  function automatic logic mbx_decode(input logic       op,
                                      input logic       wr_n,
                                      input logic [7:0] addr,
                                      input logic [7:0] mbx_addr);
    return op && !wr_n && (addr == mbx_addr);
  endfunction

  // Rising-edge test on a registered level.
  function automatic logic rise_of(input logic now_lvl, input logic prev_lvl);
    return now_lvl && !prev_lvl;
  endfunction

endpackage

// File: rtl/mbx_bus_capture.sv
module mbx_bus_capture #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int MBX_ADDR = 10
) (
  input  logic              rst_n,
  input  logic              bus_cmd,
  input  logic              bus_op,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              dec_q,
  output logic [DATA_W-1:0] data_q
);
  import mbx_pkg::*;

  localparam logic [7:0] MBX_A8 = 8'(MBX_ADDR);

  logic              la_op;
  logic              la_wr_n;
  logic [ADDR_W-1:0] la_addr;
  logic [DATA_W-1:0] la_wdata;
  logic              hit;

  // Pins latched on the rising edge of the command strobe.
  always_ff @(posedge bus_cmd or negedge rst_n) begin
    if (!rst_n) begin
      la_op    <= 1'b0;
      la_wr_n  <= 1'b1;
      la_addr  <= '0;
      la_wdata <= '0;
    end else begin
      la_op    <= bus_op;
      la_wr_n  <= bus_wr_n;
      la_addr  <= bus_addr;
      la_wdata <= bus_wdata;
    end
  end

  // The decode settles during the strobe-high phase and is registered on its fall.
  assign hit = mbx_decode(la_op, la_wr_n, 8'(la_addr), MBX_A8);

  always_ff @(negedge bus_cmd or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= 1'b0;
      data_q <= '0;
    end else begin
      dec_q <= hit;
      if (hit) data_q <= la_wdata;
    end
  end
endmodule

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stg;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= 1'b0;
          else        stg[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= 1'b0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/mbx_edge_flag.sv
module mbx_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic clr,
  output logic set_pulse,
  output logic flag
);
  import mbx_pkg::*;

  logic lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl;
  end

  assign set_pulse = rise_of(lvl, lvl_prev);

  // Set has priority over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (set_pulse) flag <= 1'b1;
    else if (clr)       flag <= 1'b0;
  end
endmodule

// File: rtl/mbx_attn_cdc.sv
module mbx_attn_cdc #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int MBX_ADDR    = 10,
  parameter int SYNC_STAGES = 3
) (
  input  logic              rst_n,
  input  logic              bus_cmd,
  input  logic              bus_op,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              main_clk,
  input  logic              mbx_clr,
  output logic              mbx_flag,
  output logic [DATA_W-1:0] mbx_data
);
  logic dec_q;      // registered decode, bus domain
  logic sync_lvl;   // synchronized decode level, main domain
  logic set_pulse;  // one-cycle set event, main domain

  mbx_bus_capture #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MBX_ADDR(MBX_ADDR)
  ) u_cap (
    .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_op(bus_op), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dec_q(dec_q), .data_q(mbx_data)
  );

  mbx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(main_clk), .rst_n(rst_n), .d_async(dec_q), .q_sync(sync_lvl)
  );

  mbx_edge_flag u_flag (
    .clk(main_clk), .rst_n(rst_n), .lvl(sync_lvl), .clr(mbx_clr),
    .set_pulse(set_pulse), .flag(mbx_flag)
  );
endmodule

// File: rtl/mbx_attn_chk.sv
module mbx_attn_chk (
  input logic main_clk,
  input logic rst_n,
  input logic mbx_clr,
  input logic mbx_flag,
  input logic set_pulse
);
  AST_FLAG_RISE_NEEDS_SET: assert property (@(posedge main_clk) disable iff (!rst_n)
    $rose(mbx_flag) |-> $past(set_pulse)); // R2
  AST_FLAG_STICKY: assert property (@(posedge main_clk) disable iff (!rst_n)
    (mbx_flag && !mbx_clr) |=> mbx_flag); // R4
  AST_CLEAR_DROPS: assert property (@(posedge main_clk) disable iff (!rst_n)
    (mbx_clr && !set_pulse) |=> !mbx_flag); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge main_clk) disable iff (!rst_n)
    set_pulse |=> mbx_flag); // R6
  AST_SET_SINGLE_CYCLE: assert property (@(posedge main_clk) disable iff (!rst_n)
    set_pulse |=> !set_pulse); // R9
endmodule

bind mbx_attn_cdc mbx_attn_chk u_chk (
  .main_clk(main_clk), .rst_n(rst_n), .mbx_clr(mbx_clr),
  .mbx_flag(mbx_flag), .set_pulse(set_pulse)
);

// File: tb/mbx_attn_cdc_tb.sv
`timescale 1ns/1ps
module mbx_attn_cdc_tb;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam logic [AW-1:0] MBX = 4'hA;

  logic          main_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_cmd = 1'b0;
  logic          bus_op = 1'b0;
  logic          bus_wr_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          mbx_clr = 1'b0;
  logic          mbx_flag;
  logic [DW-1:0] mbx_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 main_clk = ~main_clk;

  mbx_attn_cdc u_dut (
    .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_op(bus_op), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .main_clk(main_clk),
    .mbx_clr(mbx_clr), .mbx_flag(mbx_flag), .mbx_data(mbx_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge main_clk);
  endtask

  // Drives one access; returns at the strobe fall, which sits on a main_clk falling edge.
  task automatic bus_access(input logic op, input logic wr_n,
                            input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge main_clk);
    bus_op = op; bus_wr_n = wr_n; bus_addr = a; bus_wdata = d;
    #1 bus_cmd = 1'b1;
    @(negedge main_clk);
    bus_cmd = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge main_clk);
    mbx_clr = 1'b1;
    @(negedge main_clk);
    mbx_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flag in reset", mbx_flag, 0);
    chk("R1 data in reset", mbx_data, 0);
    @(negedge main_clk);
    rst_n = 1'b1;
    idle(2);
    chk("R1 flag after release", mbx_flag, 0);
  endtask

  task automatic t_latency();
    bus_access(1'b1, 1'b0, MBX, 16'h1234);
    idle(2);
    chk("R2 flag not after 2 edges", mbx_flag, 0);
    idle(1);
    chk("R2 flag not after 3 edges", mbx_flag, 0);
    idle(1);
    chk("R2 flag after 4 edges", mbx_flag, 1);
    chk("R7 data loaded", mbx_data, 16'h1234);
  endtask

  task automatic t_sticky_clear();
    idle(20);
    chk("R4 flag held", mbx_flag, 1);
    pulse_clear();
    chk("R5 flag cleared", mbx_flag, 0);
  endtask

  task automatic t_repeat_write();
    bus_access(1'b1, 1'b0, MBX, 16'h5678);
    idle(8);
    chk("R9 no set on repeated level", mbx_flag, 0);
    chk("R7 data from repeat write", mbx_data, 16'h5678);
  endtask

  task automatic t_no_false_set();
    bus_access(1'b1, 1'b0, 4'h3, 16'hBEEF);
    idle(8);
    chk("R3 other address", mbx_flag, 0);
    chk("R7 data held on other write", mbx_data, 16'h5678);
    bus_access(1'b1, 1'b1, MBX, 16'h1111);
    idle(8);
    chk("R3 read of mailbox", mbx_flag, 0);
    bus_access(1'b0, 1'b0, MBX, 16'h2222);
    idle(8);
    chk("R3 op inactive", mbx_flag, 0);
    bus_access(1'b1, 1'b0, 4'hB, 16'h3333);
    idle(8);
    chk("R3 neighbour address", mbx_flag, 0);
    chk("R7 data held after misses", mbx_data, 16'h5678);
  endtask

  task automatic t_runt_pulse();
    @(negedge main_clk);
    bus_op = 1'b1; bus_wr_n = 1'b0; bus_addr = MBX; bus_wdata = 16'hDEAD;
    #2;
    bus_op = 1'b0; bus_wr_n = 1'b1; bus_addr = '0; bus_wdata = '0;
    idle(10);
    chk("R8 runt pulse flag", mbx_flag, 0);
    chk("R8 runt pulse data", mbx_data, 16'h5678);
  endtask

  task automatic t_set_wins();
    bus_access(1'b1, 1'b0, MBX, 16'h0C0C);
    idle(8);
    chk("R2 flag set again", mbx_flag, 1);
    bus_access(1'b1, 1'b0, 4'h1, 16'h0000);
    idle(8);
    bus_access(1'b1, 1'b0, MBX, 16'hA5A5);
    idle(3);
    mbx_clr = 1'b1;
    @(negedge main_clk);
    mbx_clr = 1'b0;
    chk("R6 set beats clear", mbx_flag, 1);
    idle(4);
    chk("R6 flag still set", mbx_flag, 1);
    pulse_clear();
    chk("R5 plain clear", mbx_flag, 0);
    chk("R7 data after set-clear race", mbx_data, 16'hA5A5);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_latency();
    t_sticky_clear();
    t_repeat_write();
    t_no_false_set();
    t_runt_pulse();
    t_set_wins();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule